// File: doc/BRIEF.md
# Out-of-Order DRAM Command Scheduler

This block sits between a stream of memory requests and the DRAM command bus. Requests carry a bank, a row, a column, a write flag and a requester tag. They enter a small associative queue through a valid/ready port. In every DRAM cycle the scheduler looks at all queued requests and derives the one command each request needs next. A request to an open bank whose row matches needs a column access. A request to a closed bank needs an activate. A request to a bank holding another row needs a precharge.

A request may issue only when its bank has finished the latency of the previous command sent to it. Among the requests that may issue, column accesses win over precharge and activate. Any remaining tie goes to the request that arrived first. This groups hits to an open row and lets banks work in parallel. When the column access of a request issues, the request retires: a pulse carries its tag and its queue slot is freed. The precharge, activate and column latencies are inputs, so one build serves several speed grades. Data transfer and refresh are handled elsewhere.

Top module: `oo_dram_sched`

## Requirements
- R1: `in_ready` is high while fewer than DEPTH requests are queued and low when all DEPTH slots are occupied; a request is taken only in a cycle with `in_valid` and `in_ready` both high, and an offer made while `in_ready` is low has no effect.
- R2: `cmd_op` encodes 0 = no command, 1 = precharge, 2 = activate, 3 = column access. At most one command is issued per cycle. After reset there is no command and no retire pulse, the queue is empty and every bank is closed.
- R3: A request whose bank holds its row issues only a column access. A request to a closed bank issues activate and then column. A request to a bank holding another row issues precharge, then activate, then column. `cmd_bank`, `cmd_row` and `cmd_col` give the target of the command.
- R4: After a command issues to a bank in cycle c, with latency t taken from `t_pre`, `t_act` or `t_col` by command type, the next command to that bank can issue no earlier than cycle c+t.
- R5: A request whose command may issue this cycle is chosen over an older request whose bank is still busy.
- R6: Among requests that may issue, a column access is chosen over a precharge or activate, even one from an older request.
- R7: Among requests that may issue with the same command class, the one accepted earliest is chosen.
- R8: In the cycle a column access issues, `retire_valid` pulses with that request's `retire_tag`; the slot is free from the next cycle, so a full queue raises `in_ready` again.
- R9: A command to one bank can issue while another bank is still counting down the latency of its own command.
- R10: A request accepted at a clock edge is eligible for its first command in the cycle directly after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Queue has a free slot |
| in_bank | input | BANK_W | Request bank |
| in_row | input | ROW_W | Request row |
| in_col | input | COL_W | Request column |
| in_wr | input | 1 | Request is a write |
| in_tag | input | TAG_W | Requester tag returned at retire |
| t_pre | input | TIME_W | Precharge latency in cycles (at least 1) |
| t_act | input | TIME_W | Activate latency in cycles (at least 1) |
| t_col | input | TIME_W | Column latency in cycles (at least 1) |
| cmd_op | output | 2 | Command issued this cycle |
| cmd_bank | output | BANK_W | Bank of the issued command |
| cmd_row | output | ROW_W | Row of the issued command |
| cmd_col | output | COL_W | Column of the issued command |
| cmd_wr | output | 1 | Write flag of the issued command |
| retire_valid | output | 1 | A request completes this cycle |
| retire_tag | output | TAG_W | Tag of the completing request |

## Verification
The bench uses the default build: two banks, 4-bit rows and columns, an eight-entry queue and a 4-bit latency field. The 4-bit field allows a 15-cycle precharge, which holds a bank long enough for the whole queue to fill. That exposes back-pressure, the grouping of row hits ahead of older conflicting requests, and the age order among them. With only two banks, a long precharge on one bank next to a row hit on the other shows bank overlap and the ready-first rule in a handful of cycles. Short single-request vectors at the default latencies check the hit, closed and conflict sequences and their exact issue cycles.

// File: rtl/sched_pkg.sv
package sched_pkg;

   typedef enum logic [1:0] {
      OP_NOP = 2'd0,
      OP_PRE = 2'd1,
      OP_ACT = 2'd2,
      OP_COL = 2'd3
   } sched_op_e;

endpackage

// File: rtl/sched_bank.sv
module sched_bank
   import sched_pkg::*;
#(
   parameter int ROW_W  = 4,
   parameter int TIME_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  sched_op_e         op,
   input  logic [ROW_W-1:0]  row,
   input  logic [TIME_W-1:0] t_pre,
   input  logic [TIME_W-1:0] t_act,
   input  logic [TIME_W-1:0] t_col,
   output logic              open_o,
   output logic [ROW_W-1:0]  row_o,
   output logic              idle_o
);

   logic [TIME_W-1:0] busy_q;
   logic [TIME_W-1:0] lat;
   logic              open_q;
   logic [ROW_W-1:0]  row_q;

   always_comb begin
      case (op)
         OP_PRE:  lat = t_pre;
         OP_ACT:  lat = t_act;
         default: lat = t_col;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= '0;
         open_q <= 1'b0;
         row_q  <= '0;
      end else if (issue) begin
         busy_q <= (lat == '0) ? '0 : lat - 1'b1;
         if (op == OP_PRE) begin
            open_q <= 1'b0;
         end else if (op == OP_ACT) begin
            open_q <= 1'b1;
            row_q  <= row;
         end
      end else if (busy_q != '0) begin
         busy_q <= busy_q - 1'b1;
      end
   end

   assign open_o = open_q;
   assign row_o  = row_q;
   assign idle_o = (busy_q == '0);

   // R4: the picker never targets a bank that is still counting down
   p_issue_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> busy_q == '0);

   // R3: activate only into a closed bank, column and precharge only into an open one
   p_act_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && op == OP_ACT) |-> !open_q);
   p_col_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && op != OP_ACT) |-> open_q);

   // R3: a column access leaves the open row untouched
   p_col_keeps_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && op == OP_COL) |=> (open_q && row_q == $past(row)));

endmodule

// File: rtl/sched_pick.sv
module sched_pick #(
   parameter int DEPTH   = 8,
   parameter int STAMP_W = 8,
   localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [DEPTH-1:0]                cand,
   input  logic [DEPTH-1:0]                is_col,
   input  logic [DEPTH-1:0][STAMP_W-1:0]   stamp,
   output logic                            win_v,
   output logic [IDX_W-1:0]                win_idx
);

   // wrap-safe age compare: a arrived before b
   function automatic logic older(input logic [STAMP_W-1:0] a,
                                  input logic [STAMP_W-1:0] b);
      logic [STAMP_W-1:0] d;
      d = a - b;
      return d[STAMP_W-1];
   endfunction

   always_comb begin
      win_v   = 1'b0;
      win_idx = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (cand[i]) begin
            if (!win_v
                || (is_col[i] && !is_col[win_idx])
                || (is_col[i] == is_col[win_idx] && older(stamp[i], stamp[win_idx]))) begin
               win_v   = 1'b1;
               win_idx = IDX_W'(i);
            end
         end
      end
   end

   // R5: the winner is always a request that may issue now
   p_win_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      win_v |-> cand[win_idx]);
   p_no_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|cand) |-> win_v);

   // R6: a row-opening command wins only when no column access is ready
   p_col_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_v && !is_col[win_idx]) |-> !(|(cand & is_col)));

endmodule

// File: rtl/oo_dram_sched.sv
module oo_dram_sched
   import sched_pkg::*;
#(
   parameter int BANKS   = 2,
   parameter int ROW_W   = 4,
   parameter int COL_W   = 4,
   parameter int TAG_W   = 3,
   parameter int DEPTH   = 8,
   parameter int TIME_W  = 4,
   parameter int STAMP_W = 8,
   localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
   localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [BANK_W-1:0] in_bank,
   input  logic [ROW_W-1:0]  in_row,
   input  logic [COL_W-1:0]  in_col,
   input  logic              in_wr,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic [TIME_W-1:0] t_pre,
   input  logic [TIME_W-1:0] t_act,
   input  logic [TIME_W-1:0] t_col,
   output logic [1:0]        cmd_op,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [ROW_W-1:0]  cmd_row,
   output logic [COL_W-1:0]  cmd_col,
   output logic              cmd_wr,
   output logic              retire_valid,
   output logic [TAG_W-1:0]  retire_tag
);

   initial begin
      assert (DEPTH >= 2) else $error("queue needs at least two slots");
      assert ((BANKS & (BANKS - 1)) == 0) else $error("bank count must be a power of two");
      assert (STAMP_W > IDX_W) else $error("stamp must be wider than the slot index");
   end

   // ---------------- queue storage ----------------
   logic [DEPTH-1:0]              vld_q;
   logic [BANK_W-1:0]             bank_q [DEPTH];
   logic [ROW_W-1:0]              row_q  [DEPTH];
   logic [COL_W-1:0]              col_q  [DEPTH];
   logic [DEPTH-1:0]              wr_q;
   logic [TAG_W-1:0]              tag_q  [DEPTH];
   logic [DEPTH-1:0][STAMP_W-1:0] stamp_q;
   logic [STAMP_W-1:0]            next_stamp_q;

   // ---------------- bank state ----------------
   logic              bank_open [BANKS];
   logic [ROW_W-1:0]  bank_row  [BANKS];
   logic              bank_idle [BANKS];
   logic [BANKS-1:0]  bank_issue;

   // ---------------- selection ----------------
   sched_op_e         need_op [DEPTH];
   logic [DEPTH-1:0]  cand;
   logic [DEPTH-1:0]  is_col;
   logic              win_v;
   logic [IDX_W-1:0]  win_idx;
   sched_op_e         sel_op;

   logic              has_free;
   logic [IDX_W-1:0]  free_idx;
   logic              enq;

   always_comb begin
      has_free = 1'b0;
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!vld_q[i]) begin
            has_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   assign in_ready = has_free;
   assign enq      = in_valid && has_free;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         if (!bank_open[bank_q[i]])
            need_op[i] = OP_ACT;
         else if (bank_row[bank_q[i]] == row_q[i])
            need_op[i] = OP_COL;
         else
            need_op[i] = OP_PRE;
         cand[i]   = vld_q[i] && bank_idle[bank_q[i]];
         is_col[i] = (need_op[i] == OP_COL);
      end
   end

   sched_pick #(
      .DEPTH   (DEPTH),
      .STAMP_W (STAMP_W)
   ) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .cand    (cand),
      .is_col  (is_col),
      .stamp   (stamp_q),
      .win_v   (win_v),
      .win_idx (win_idx)
   );

   assign sel_op = win_v ? need_op[win_idx] : OP_NOP;

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      assign bank_issue[b] = win_v && (bank_q[win_idx] == BANK_W'(b));

      sched_bank #(
         .ROW_W  (ROW_W),
         .TIME_W (TIME_W)
      ) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .issue  (bank_issue[b]),
         .op     (sel_op),
         .row    (row_q[win_idx]),
         .t_pre  (t_pre),
         .t_act  (t_act),
         .t_col  (t_col),
         .open_o (bank_open[b]),
         .row_o  (bank_row[b]),
         .idle_o (bank_idle[b])
      );
   end

   // ---------------- queue update ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q        <= '0;
         next_stamp_q <= '0;
      end else begin
         if (enq) begin
            vld_q[free_idx] <= 1'b1;
            next_stamp_q    <= next_stamp_q + 1'b1;
         end
         if (sel_op == OP_COL)
            vld_q[win_idx] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (enq) begin
         bank_q[free_idx]  <= in_bank;
         row_q[free_idx]   <= in_row;
         col_q[free_idx]   <= in_col;
         wr_q[free_idx]    <= in_wr;
         tag_q[free_idx]   <= in_tag;
         stamp_q[free_idx] <= next_stamp_q;
      end
   end

   // ---------------- outputs ----------------
   assign cmd_op       = sel_op;
   assign cmd_bank     = bank_q[win_idx];
   assign cmd_row      = row_q[win_idx];
   assign cmd_col      = col_q[win_idx];
   assign cmd_wr       = wr_q[win_idx];
   assign retire_valid = (sel_op == OP_COL);
   assign retire_tag   = tag_q[win_idx];

   // R1: a fully occupied queue refuses new requests
   p_full_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (&vld_q) |-> !in_ready);

   // R2: a single bank receives the command of a cycle
   p_one_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_issue));

   // R8: the slot of a retired request is empty in the next cycle
   p_slot_freed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      retire_valid |=> !vld_q[$past(win_idx)]);

endmodule

// File: tb/oo_dram_sched_test.sv
module oo_dram_sched_test;

   localparam int TP = 3;
   localparam int TA = 3;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_valid;
   logic       in_ready;
   logic [0:0] in_bank;
   logic [3:0] in_row;
   logic [3:0] in_col;
   logic       in_wr;
   logic [2:0] in_tag;
   logic [3:0] t_pre, t_act, t_col;
   logic [1:0] cmd_op;
   logic [0:0] cmd_bank;
   logic [3:0] cmd_row;
   logic [3:0] cmd_col;
   logic       cmd_wr;
   logic       retire_valid;
   logic [2:0] retire_tag;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   oo_dram_sched uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .in_bank      (in_bank),
      .in_row       (in_row),
      .in_col       (in_col),
      .in_wr        (in_wr),
      .in_tag       (in_tag),
      .t_pre        (t_pre),
      .t_act        (t_act),
      .t_col        (t_col),
      .cmd_op       (cmd_op),
      .cmd_bank     (cmd_bank),
      .cmd_row      (cmd_row),
      .cmd_col      (cmd_col),
      .cmd_wr       (cmd_wr),
      .retire_valid (retire_valid),
      .retire_tag   (retire_tag)
   );

   // {bank, row, col, kind}; kind 0 = row hit, 1 = closed bank, 2 = row conflict
   localparam logic [10:0] VEC [8] = '{
      {1'b0, 4'd5, 4'd1, 2'd1},
      {1'b0, 4'd5, 4'd2, 2'd0},
      {1'b1, 4'd3, 4'd0, 2'd1},
      {1'b0, 4'd9, 4'd4, 2'd2},
      {1'b1, 4'd3, 4'd7, 2'd0},
      {1'b1, 4'd6, 4'd1, 2'd2},
      {1'b0, 4'd9, 4'd0, 2'd0},
      {1'b1, 4'd6, 4'd2, 2'd0}
   };

   task automatic nxt();
      @(negedge clk);
      #1;
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic offer(input logic b, input logic [3:0] r, input logic [3:0] c,
                        input logic [2:0] tg);
      in_valid = 1'b1;
      in_bank  = b;
      in_row   = r;
      in_col   = c;
      in_wr    = tg[0];
      in_tag   = tg;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int mism;
      int ntags;
      int order [8];
      int ready_back;
      int seen_nop;
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_bank  = '0;
      in_row   = '0;
      in_col   = '0;
      in_wr    = 1'b0;
      in_tag   = '0;
      t_pre    = 4'(TP);
      t_act    = 4'(TA);
      t_col    = 4'd1;
      repeat (3) nxt();

      // R2: reset state
      check(cmd_op == 2'd0, "R2 reset command", cmd_op, 0);
      check(retire_valid == 1'b0, "R2 reset retire", retire_valid, 0);
      check(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
      rst_n = 1'b1;
      nxt();

      // table: one request at a time, trace every cycle (R3 R4 R8 R10)
      for (int v = 0; v < 8; v++) begin
         logic       vb;
         logic [3:0] vr, vc;
         int         kind;
         vb   = VEC[v][10];
         vr   = VEC[v][9:6];
         vc   = VEC[v][5:2];
         kind = int'(VEC[v][1:0]);
         check(in_ready == 1'b1, "R1 ready before offer", in_ready, 1);
         offer(vb, vr, vc, 3'(v));
         mism = 0;
         for (int k = 1; k <= 12; k++) begin
            int ep;
            nxt();
            if (k == 1) in_valid = 1'b0;
            ep = 0;
            case (kind)
               0: if (k == 1) ep = 3;
               1: if (k == 1) ep = 2; else if (k == 1 + TA) ep = 3;
               default: if (k == 1) ep = 1; else if (k == 1 + TP) ep = 2;
                        else if (k == 1 + TP + TA) ep = 3;
            endcase
            if (int'(cmd_op) != ep) mism++;
            if (ep != 0 && cmd_bank != vb) mism++;
            if (ep == 3 && (cmd_row != vr || cmd_col != vc || !retire_valid
                            || retire_tag != 3'(v) || cmd_wr != v[0])) mism++;
            if (ep != 3 && retire_valid) mism++;
         end
         check(mism == 0, $sformatf("R3 R4 R8 R10 vector %0d trace", v), mism, 0);
      end

      // full queue, back-pressure, column-first and age order (R1 R6 R7 R8)
      t_pre = 4'd15;
      for (int i = 0; i < 8; i++) begin
         check(in_ready == 1'b1, "R1 ready while filling", in_ready, 1);
         offer(1'b0, (i % 2 == 0) ? 4'd1 : 4'd2, 4'(i), 3'(i));
         nxt();
      end
      check(in_ready == 1'b0, "R1 full queue not ready", in_ready, 0);
      offer(1'b1, 4'd6, 4'd9, 3'd3);   // refused offer, would hit bank 1 at once
      nxt();
      in_valid = 1'b0;
      ntags = 0;
      ready_back = 0;
      for (int k = 0; k < 150; k++) begin
         if (ntags == 1 && ready_back == 0)
            ready_back = in_ready ? 1 : 2;
         if (retire_valid) begin
            if (ntags < 8) order[ntags] = int'(retire_tag);
            ntags++;
         end
         nxt();
      end
      check(ntags == 8, "R1 refused offer had no effect", ntags, 8);
      check(ready_back == 1, "R8 ready after first retire", ready_back, 1);
      check(order[0] == 0 && order[1] == 2 && order[2] == 4 && order[3] == 6,
            "R6 hits of open row before older conflict", order[1], 2);
      check(order[4] == 1 && order[5] == 3 && order[6] == 5 && order[7] == 7,
            "R7 oldest first within second row", order[4], 1);

      // ready-first and bank overlap (R5 R9 R4 R10); bank0 holds row 2, bank1 row 6
      t_pre = 4'd10;
      offer(1'b0, 4'd7, 4'd3, 3'd1);
      nxt();
      check(cmd_op == 2'd1 && cmd_bank == 1'b0, "R10 precharge right after accept",
            cmd_op, 1);
      offer(1'b1, 4'd6, 4'd5, 3'd2);
      nxt();
      in_valid = 1'b0;
      check(cmd_op == 2'd3 && cmd_bank == 1'b1, "R9 bank1 column during bank0 precharge",
            cmd_op, 3);
      check(retire_valid && retire_tag == 3'd2, "R5 younger ready request served first",
            retire_tag, 2);
      seen_nop = 1;
      for (int k = 3; k <= 10; k++) begin
         nxt();
         if (k <= 10 && cmd_op != 2'd0) seen_nop = 0;
      end
      check(seen_nop == 1, "R4 bank0 silent during precharge", seen_nop, 1);
      nxt();
      check(cmd_op == 2'd2 && cmd_bank == 1'b0, "R4 activate exactly t_pre later",
            cmd_op, 2);
      nxt();
      nxt();
      nxt();
      check(cmd_op == 2'd3 && retire_tag == 3'd1, "R3 column closes the conflict",
            cmd_op, 3);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule